// File: doc/BRIEF.md
# Multi-Design Scan Chain Controller

This block runs a long serial scan chain in which many small user designs are linked one after another. Each design owns a 16-bit slot in the chain: eight input bits followed by eight output bits. A select value picks one design. On every refresh the controller samples the select and the eight input values. It then shifts a whole frame into the chain, with the input values placed in the selected design's slot and zeros everywhere else. It pulses a latch enable so that every design takes its new inputs, and pulses a scan-select strobe so that every design's outputs are captured into the chain. Finally it shifts the whole chain out and picks the selected design's eight outputs from the returning bit stream.

Each chain bit costs two system clocks. In the first the data line is set up with the scan clock low, and in the second the scan clock rises. When a refresh completes, the captured byte is loaded into the output register and a one-cycle ready pulse is issued. Refreshes then run back to back. A two-bit driver select hands the chain pins either to this sequencer, to a set of external pins or to a firmware-driven set of signals. The bit returning from the end of the chain, and its clock, are always passed back out.

Top module: `scan_chain_ctrl`

## Requirements
- R1: While reset is asserted with the internal driver selected, des_out is 0, ready is 0, and chain_clk, chain_sel and chain_latch are all low.
- R2: ready is high for exactly one clock per refresh. With the internal driver selected, consecutive ready pulses are 4*NUM_DESIGNS*16+5 clocks apart, and the first pulse after reset release comes that many clocks after the release.
- R3: Chain position 0 is the flop nearest chain_data. Design k owns positions 16k..16k+15. Its input bit j sits at position 16k+j and its output bit j at position 16k+8+j. After a refresh with active_sel = k < NUM_DESIGNS, design k has latched des_in, and des_out holds the outputs that design k presented at the capture.
- R4: In every shifted frame, all chain positions outside the active design's input field are 0, so every other design latches 0.
- R5: With the internal driver, each chain bit takes two clocks and chain_data is stable across each rising chain_clk. A refresh shows exactly 2*NUM_DESIGNS*16+1 rising chain_clk edges (shift in, one capture, shift out).
- R6: After the shift-in, chain_latch is high for exactly 2 clocks with chain_clk low. After that, chain_sel is high for exactly 2 clocks, during which chain_clk rises exactly once. chain_latch and chain_sel are never high together.
- R7: des_out changes only in the cycle in which ready is high.
- R8: An active_sel value of NUM_DESIGNS or more matches no slot: every design latches 0 and des_out becomes 0 after that refresh.
- R9: active_sel and des_in are sampled once, in the first cycle of a refresh; changing them later in the refresh does not affect its result.
- R10: drv_sel 00 routes ext_clk/ext_data/ext_sel/ext_latch to the chain pins, 01 routes fw_clk/fw_data/fw_sel/fw_latch, and 1x routes the internal sequencer. ret_clk and ret_data always follow tail_clk and tail_data.
- R11: While drv_sel[1] is 0, the sequencer is idle: ready stays 0 and des_out holds. When drv_sel[1] returns to 1, a fresh refresh begins on the next clock and completes after the R2 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_sel | input | 2 | Chain driver choice: 00 external, 01 firmware, 1x internal |
| active_sel | input | 9 | Index of the active design |
| des_in | input | 8 | Input byte for the active design |
| des_out | output | 8 | Output byte captured from the active design |
| ready | output | 1 | One-cycle pulse at the end of each refresh |
| ext_clk | input | 1 | External driver scan clock |
| ext_data | input | 1 | External driver scan data |
| ext_sel | input | 1 | External driver scan-select |
| ext_latch | input | 1 | External driver latch enable |
| fw_clk | input | 1 | Firmware driver scan clock |
| fw_data | input | 1 | Firmware driver scan data |
| fw_sel | input | 1 | Firmware driver scan-select |
| fw_latch | input | 1 | Firmware driver latch enable |
| chain_clk | output | 1 | Scan clock into the chain |
| chain_data | output | 1 | Scan data into the chain |
| chain_sel | output | 1 | Scan-select (capture) strobe into the chain |
| chain_latch | output | 1 | Latch enable into the chain |
| tail_clk | input | 1 | Clock returning from the end of the chain |
| tail_data | input | 1 | Data returning from the end of the chain |
| ret_clk | output | 1 | Returned clock passed back to the drivers |
| ret_data | output | 1 | Returned data passed back to the drivers |

## Verification
The bench builds the controller with NUM_DESIGNS set to 4. This gives a 64-bit chain and a 261-clock refresh, so back-to-back refreshes, the driver hand-over and the idle period all fit in a few thousand cycles. At that size the first slot, the last slot, an unused index just past the end and the largest select value 511 can all be reached. The bench models the chain and the designs at the bit level, which lets it check the frame contents and the captured byte for each of these.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_SHIN  = 3'd1,
        ST_LATCH = 3'd2,
        ST_CAPT  = 3'd3,
        ST_SHOUT = 3'd4
    } sc_state_e;

    localparam logic [1:0] DRV_EXT = 2'b00;
    localparam logic [1:0] DRV_FW  = 2'b01;

endpackage

// File: rtl/sc_slot_decode.sv
module sc_slot_decode #(
    parameter int SEL_W  = 9,
    parameter int DATA_W = 8,
    parameter int POS_W  = 13
) (
    input  logic [POS_W-1:0]                  pos,
    input  logic [SEL_W-1:0]                  sel,
    input  logic [DATA_W-1:0]                 din,
    output logic                              in_bit,
    output logic                              out_hit,
    output logic [$clog2(2*DATA_W)-2:0]       bit_idx
);
    localparam int SLOT_W = 2 * DATA_W;
    localparam int OFF_W  = $clog2(SLOT_W);
    localparam int CMP_W  = (SEL_W > POS_W) ? SEL_W : POS_W;

    logic [CMP_W-1:0] slot_num;
    logic [CMP_W-1:0] sel_ext;
    logic             hit;
    logic             upper;

    assign slot_num = CMP_W'(pos >> OFF_W);
    assign sel_ext  = CMP_W'(sel);
    assign hit      = (slot_num == sel_ext);
    assign upper    = pos[OFF_W-1];
    assign bit_idx  = pos[OFF_W-2:0];
    assign in_bit   = hit && !upper && din[bit_idx];
    assign out_hit  = hit && upper;

endmodule

// File: rtl/sc_capture_merge.sv
module sc_capture_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]           acc,
    input  logic                        hit,
    input  logic [$clog2(DATA_W)-1:0]   bit_idx,
    input  logic                        tail,
    output logic [DATA_W-1:0]           acc_new
);
    localparam int IDX_W = $clog2(DATA_W);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign acc_new[i] = (hit && (bit_idx == IDX_W'(i))) ? tail : acc[i];
    end

endmodule

// File: rtl/sc_drv_mux.sv
module sc_drv_mux
    import sc_pkg::*;
(
    input  logic [1:0] drv_sel,
    input  logic       int_clk,
    input  logic       int_data,
    input  logic       int_sel,
    input  logic       int_latch,
    input  logic       ext_clk,
    input  logic       ext_data,
    input  logic       ext_sel,
    input  logic       ext_latch,
    input  logic       fw_clk,
    input  logic       fw_data,
    input  logic       fw_sel,
    input  logic       fw_latch,
    input  logic       tail_clk,
    input  logic       tail_data,
    output logic       chain_clk,
    output logic       chain_data,
    output logic       chain_sel,
    output logic       chain_latch,
    output logic       ret_clk,
    output logic       ret_data
);
    always_comb begin
        if (drv_sel[1]) begin
            chain_clk   = int_clk;
            chain_data  = int_data;
            chain_sel   = int_sel;
            chain_latch = int_latch;
        end else if (drv_sel == DRV_FW) begin
            chain_clk   = fw_clk;
            chain_data  = fw_data;
            chain_sel   = fw_sel;
            chain_latch = fw_latch;
        end else begin
            chain_clk   = ext_clk;
            chain_data  = ext_data;
            chain_sel   = ext_sel;
            chain_latch = ext_latch;
        end
    end

    assign ret_clk  = tail_clk;
    assign ret_data = tail_data;

endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
    import sc_pkg::*;
#(
    parameter int NUM_DESIGNS = 498,
    parameter int SEL_W       = 9,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        drv_sel,
    input  logic [SEL_W-1:0]  active_sel,
    input  logic [DATA_W-1:0] des_in,
    output logic [DATA_W-1:0] des_out,
    output logic              ready,
    input  logic              ext_clk,
    input  logic              ext_data,
    input  logic              ext_sel,
    input  logic              ext_latch,
    input  logic              fw_clk,
    input  logic              fw_data,
    input  logic              fw_sel,
    input  logic              fw_latch,
    output logic              chain_clk,
    output logic              chain_data,
    output logic              chain_sel,
    output logic              chain_latch,
    input  logic              tail_clk,
    input  logic              tail_data,
    output logic              ret_clk,
    output logic              ret_data
);
    localparam int SLOT_W = 2 * DATA_W;
    localparam int OFF_W  = $clog2(SLOT_W);
    localparam int IDX_W  = OFF_W - 1;
    localparam int TOTAL  = NUM_DESIGNS * SLOT_W;
    localparam int POS_W  = $clog2(TOTAL);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(TOTAL - 1);

    typedef struct packed {
        sc_state_e         st;
        logic              ph;
        logic [POS_W-1:0]  pos;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] dout;
        logic              rdy;
        logic              sclk;
        logic              sdata;
        logic              ssel;
        logic              slat;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_START, ph: 1'b0, pos: '0, sel: '0, din: '0, acc: '0,
        dout: '0, rdy: 1'b0, sclk: 1'b0, sdata: 1'b0, ssel: 1'b0, slat: 1'b0
    };

    regs_t             q;
    regs_t             d;
    logic              int_en;
    logic              frame_bit;
    logic              out_hit;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] acc_new;

    assign int_en = drv_sel[1];

    // Which chain position the sequencer is on, and what belongs there
    sc_slot_decode #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W),
        .POS_W  (POS_W)
    ) u_dec (
        .pos     (q.pos),
        .sel     (q.sel),
        .din     (q.din),
        .in_bit  (frame_bit),
        .out_hit (out_hit),
        .bit_idx (bit_idx)
    );

    // Folds the bit arriving from the chain tail into the output byte
    sc_capture_merge #(
        .DATA_W (DATA_W)
    ) u_mrg (
        .acc     (q.acc),
        .hit     (out_hit),
        .bit_idx (bit_idx),
        .tail    (tail_data),
        .acc_new (acc_new)
    );

    // Combinational part: every next value is decided here
    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        if (!int_en) begin
            d.st    = ST_START;
            d.ph    = 1'b0;
            d.sclk  = 1'b0;
            d.sdata = 1'b0;
            d.ssel  = 1'b0;
            d.slat  = 1'b0;
        end else begin
            unique case (q.st)
                ST_START: begin
                    d.sel  = active_sel;
                    d.din  = des_in;
                    d.acc  = '0;
                    d.pos  = POS_LAST;
                    d.ph   = 1'b0;
                    d.sclk = 1'b0;
                    d.st   = ST_SHIN;
                end
                ST_SHIN: begin
                    if (!q.ph) begin
                        d.sdata = frame_bit;
                        d.sclk  = 1'b0;
                        d.ph    = 1'b1;
                    end else begin
                        d.sclk = 1'b1;
                        d.ph   = 1'b0;
                        if (q.pos == '0) d.st  = ST_LATCH;
                        else             d.pos = q.pos - 1'b1;
                    end
                end
                ST_LATCH: begin
                    if (!q.ph) begin
                        d.sclk  = 1'b0;
                        d.sdata = 1'b0;
                        d.slat  = 1'b1;
                        d.ph    = 1'b1;
                    end else begin
                        d.ph = 1'b0;
                        d.st = ST_CAPT;
                    end
                end
                ST_CAPT: begin
                    if (!q.ph) begin
                        d.slat = 1'b0;
                        d.ssel = 1'b1;
                        d.ph   = 1'b1;
                    end else begin
                        d.sclk = 1'b1;
                        d.ph   = 1'b0;
                        d.pos  = POS_LAST;
                        d.st   = ST_SHOUT;
                    end
                end
                ST_SHOUT: begin
                    if (!q.ph) begin
                        d.ssel = 1'b0;
                        d.sclk = 1'b0;
                        d.ph   = 1'b1;
                    end else begin
                        d.sclk = 1'b1;
                        d.ph   = 1'b0;
                        d.acc  = acc_new;
                        if (q.pos == '0) begin
                            d.st   = ST_START;
                            d.rdy  = 1'b1;
                            d.dout = acc_new;
                        end else begin
                            d.pos = q.pos - 1'b1;
                        end
                    end
                end
                default: d.st = ST_START;
            endcase
        end
    end

    // Register part
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    sc_drv_mux u_mux (
        .drv_sel     (drv_sel),
        .int_clk     (q.sclk),
        .int_data    (q.sdata),
        .int_sel     (q.ssel),
        .int_latch   (q.slat),
        .ext_clk     (ext_clk),
        .ext_data    (ext_data),
        .ext_sel     (ext_sel),
        .ext_latch   (ext_latch),
        .fw_clk      (fw_clk),
        .fw_data     (fw_data),
        .fw_sel      (fw_sel),
        .fw_latch    (fw_latch),
        .tail_clk    (tail_clk),
        .tail_data   (tail_data),
        .chain_clk   (chain_clk),
        .chain_data  (chain_data),
        .chain_sel   (chain_sel),
        .chain_latch (chain_latch),
        .ret_clk     (ret_clk),
        .ret_data    (ret_data)
    );

    assign des_out = q.dout;
    assign ready   = q.rdy;

endmodule

// File: rtl/scan_chain_ctrl_chk.sv
module scan_chain_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        drv_sel,
    input logic [DATA_W-1:0] des_out,
    input logic              ready,
    input logic              chain_clk,
    input logic              chain_data,
    input logic              chain_sel,
    input logic              chain_latch
);
    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(des_out));

    p_clk_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_sel[1] && chain_clk) |=> (!chain_clk || !drv_sel[1]));

    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_sel[1] && $past(drv_sel[1]) && $rose(chain_clk)) |-> $stable(chain_data));

    p_latch_sel_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_sel[1] |-> !(chain_latch && chain_sel));

    p_latch_no_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_sel[1] && chain_latch) |-> !chain_clk);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_sel[1] |=> !ready);

endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_sel     (drv_sel),
    .des_out     (des_out),
    .ready       (ready),
    .chain_clk   (chain_clk),
    .chain_data  (chain_data),
    .chain_sel   (chain_sel),
    .chain_latch (chain_latch)
);

// File: tb/scan_chain_ctrl_bench.sv
`timescale 1ns/1ps
module scan_chain_ctrl_bench;
    localparam int N      = 4;
    localparam int TOT    = N * 16;
    localparam int PERIOD = 4 * TOT + 5;
    localparam int NV     = 8;

    // {active_sel, des_in, expected des_out}
    localparam logic [24:0] VEC [NV] = '{
        {9'd0,   8'h3C, 8'h99},
        {9'd3,   8'hFF, 8'h57},
        {9'd1,   8'h00, 8'hA6},
        {9'd2,   8'h81, 8'h26},
        {9'd5,   8'h5A, 8'h00},
        {9'd3,   8'h01, 8'hA9},
        {9'd0,   8'h80, 8'h25},
        {9'd511, 8'hFF, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] drv_sel = 2'b10;
    logic [8:0] active_sel = '0;
    logic [7:0] des_in = '0;
    logic [7:0] des_out;
    logic       ready;
    logic ext_clk = 0, ext_data = 0, ext_sel = 0, ext_latch = 0;
    logic fw_clk = 0, fw_data = 0, fw_sel = 0, fw_latch = 0;
    logic chain_clk, chain_data, chain_sel, chain_latch;
    logic tail_clk, tail_data, ret_clk, ret_data;

    always #2.5 clk = ~clk;

    scan_chain_ctrl #(.NUM_DESIGNS(N)) u_scan_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .drv_sel(drv_sel), .active_sel(active_sel),
        .des_in(des_in), .des_out(des_out), .ready(ready),
        .ext_clk(ext_clk), .ext_data(ext_data), .ext_sel(ext_sel), .ext_latch(ext_latch),
        .fw_clk(fw_clk), .fw_data(fw_data), .fw_sel(fw_sel), .fw_latch(fw_latch),
        .chain_clk(chain_clk), .chain_data(chain_data), .chain_sel(chain_sel),
        .chain_latch(chain_latch), .tail_clk(tail_clk), .tail_data(tail_data),
        .ret_clk(ret_clk), .ret_data(ret_data)
    );

    // Bit-level model of the chain and of the user designs
    logic [TOT-1:0] chn;
    logic [7:0]     lat [N];

    function automatic logic [7:0] model_out(int k, logic [7:0] v);
        return v ^ 8'(8'hA5 + k);
    endfunction

    always @(posedge chain_clk or negedge rst_n) begin
        if (!rst_n) chn <= '0;
        else if (chain_sel) begin
            for (int k = 0; k < N; k++) chn[k*16+8 +: 8] <= model_out(k, lat[k]);
        end else chn <= {chn[TOT-2:0], chain_data};
    end

    always @(posedge chain_latch or negedge rst_n) begin
        for (int k = 0; k < N; k++) lat[k] <= rst_n ? chn[k*16 +: 8] : 8'h00;
    end

    assign tail_clk  = chain_clk;
    assign tail_data = chn[TOT-1];

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-refresh bus monitor (internal driver only)
    int   rise_cnt = 0, lat_cnt = 0, sel_cnt = 0, selrise_cnt = 0, hold_viol = 0;
    int   s_rise, s_lat, s_sel, s_selrise;
    logic prev_clk = 0;
    logic [7:0] prev_dout = 0;

    always @(negedge clk) begin
        if (drv_sel[1] && rst_n) begin
            if (chain_clk && !prev_clk) begin
                rise_cnt++;
                if (chain_sel) selrise_cnt++;
            end
            if (chain_latch) lat_cnt++;
            if (chain_sel)   sel_cnt++;
        end
        if (rst_n && !ready && des_out !== prev_dout) hold_viol++;
        prev_clk  = chain_clk;
        prev_dout = des_out;
        if (ready) begin
            s_rise = rise_cnt; s_lat = lat_cnt; s_sel = sel_cnt; s_selrise = selrise_cnt;
            rise_cnt = 0; lat_cnt = 0; sel_cnt = 0; selrise_cnt = 0;
        end
    end

    task automatic wait_ready(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ready && cyc < 5000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R2: watchdog expired, got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [7:0] hold;
        int viol;
        active_sel = VEC[0][24:16];
        des_in     = VEC[0][15:8];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(des_out == 8'h00 && ready == 1'b0, "R1", {des_out, 7'b0, ready}, 0);
        chk({chain_clk, chain_sel, chain_latch} == 3'b000, "R1",
            {chain_clk, chain_sel, chain_latch}, 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            int extra;
            extra = (i == 0) ? 0 : 20;
            wait_ready(cyc);
            #1;
            chk(cyc + extra == PERIOD, "R2", cyc + extra, PERIOD);
            if (VEC[i][24:16] < N) begin
                chk(des_out == VEC[i][7:0], "R3", des_out, VEC[i][7:0]);
                chk(lat[VEC[i][24:16]] == VEC[i][15:8], "R3", lat[VEC[i][24:16]], VEC[i][15:8]);
            end else begin
                chk(des_out == 8'h00, "R8", des_out, 0);
            end
            for (int k = 0; k < N; k++)
                if (k != int'(VEC[i][24:16]))
                    chk(lat[k] == 8'h00, "R4", lat[k], 0);
            chk(s_rise == 2 * TOT + 1, "R5", s_rise, 2 * TOT + 1);
            chk(s_lat == 2 && s_sel == 2 && s_selrise == 1, "R6",
                s_lat * 256 + s_sel * 16 + s_selrise, 'h221);
            if (i < NV - 1) begin
                active_sel = VEC[i+1][24:16];
                des_in     = VEC[i+1][15:8];
                repeat (20) @(negedge clk);
                // R9: later changes inside the refresh must be ignored
                active_sel = ~VEC[i+1][24:16];
                des_in     = ~VEC[i+1][15:8];
            end
        end
        chk(hold_viol == 0, "R7", hold_viol, 0);

        // R10: driver multiplexer
        drv_sel = 2'b00;
        ext_clk = 1; ext_data = 1; ext_sel = 1; ext_latch = 0;
        fw_clk = 0; fw_data = 0; fw_sel = 0; fw_latch = 1;
        #1;
        chk({chain_clk, chain_data, chain_sel, chain_latch} == 4'b1110, "R10",
            {chain_clk, chain_data, chain_sel, chain_latch}, 4'b1110);
        drv_sel = 2'b01;
        #1;
        chk({chain_clk, chain_data, chain_sel, chain_latch} == 4'b0001, "R10",
            {chain_clk, chain_data, chain_sel, chain_latch}, 4'b0001);
        chk(ret_clk == chain_clk && ret_data == chn[TOT-1], "R10",
            {ret_clk, ret_data}, {chain_clk, chn[TOT-1]});

        // R11: idle while an outside driver owns the chain
        @(negedge clk);
        drv_sel = 2'b00;
        fw_latch = 0; ext_sel = 0; ext_data = 0;
        hold = des_out;
        viol = 0;
        repeat (600) begin
            @(negedge clk);
            if (ready) viol++;
            if (des_out !== hold) viol++;
            ext_clk = ~ext_clk;
        end
        chk(viol == 0, "R11", viol, 0);
        ext_clk = 0;
        active_sel = 9'd1;
        des_in = 8'hF0;
        drv_sel = 2'b11;
        wait_ready(cyc);
        #1;
        chk(cyc == PERIOD, "R11", cyc, PERIOD);
        chk(des_out == 8'h56, "R11", des_out, 8'h56);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule